// File: doc/BRIEF.md
# SLIP Command Packet Decoder

This block takes a byte stream that carries SLIP-framed command packets and turns each well-formed frame into one register access request. Escape pairs are removed on the fly. The decoded frame must hold exactly seven bytes. Its integrity byte must make all seven bytes sum to zero modulo 256. When both hold, the payload is split into four fields: a sequence number, a read/write flag, a block/offset address and a signed 32-bit argument.

Frames that break any rule are dropped without a request, and a saturating error counter is bumped. The address picks one of four 32-register blocks: a misc block, or an X, Y or Z axis block. A one-hot select names the block. A write of bit 0 to the misc control register raises an emergency-stop pulse.

Input bytes use valid/ready. A byte moves only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` drops while a decoded request waits. The request uses valid/ready too. `req_valid` rises in the cycle after the closing END byte is taken. It stays high, with all request fields frozen, until a cycle where `req_ready` is high. While it waits, no input byte is taken. With `req_ready` held high, every request lasts exactly one cycle.

Top module: `slip_cmd_decoder`

## Requirements
- R1: The escape pair 0xDB,0xDC decodes to payload byte 0xC0, and the pair 0xDB,0xDD decodes to payload byte 0xDB. A lone 0xC0 byte marks a frame boundary.
- R2: Decoded payload byte 0 is the integrity byte and byte 1 is the sequence number (`req_seq`). Byte 2 is the opcode: bit 7 is `req_rd` (1 = read, 0 = write), bits 6:5 are `req_block` (0 misc, 1 X, 2 Y, 3 Z), and bits 4:0 are `req_offset`. `req_sel` is one-hot, with bit `req_block` set.
- R3: Payload bytes 3..6 form `req_wdata`, least significant byte first (byte 3 supplies bits 7:0).
- R4: A seven-byte frame whose bytes do not sum to 0 modulo 256 gives no request and adds one to `err_count`. A valid frame leaves `err_count` unchanged.
- R5: A frame whose decoded length is not seven, whether shorter or longer, gives no request and adds one to `err_count`.
- R6: Two END bytes with nothing between them give no request and leave `err_count` unchanged.
- R7: An escape byte followed by anything other than 0xDC or 0xDD drops its frame and adds one to `err_count`.
- R8: `req_valid` rises in the cycle after the closing END is accepted. It then holds, with stable fields and `in_ready` low, until it is accepted with `req_ready`.
- R9: `estop` pulses for one cycle when a write to misc offset 1 with `req_wdata[0]`=1 is accepted. There is no pulse for a read, for another block or offset, or when bit 0 is clear.
- R10: `err_count` saturates at its all-ones value.
- R11: After reset, `req_valid` is 0, `in_ready` is 1 and `err_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Raw SLIP byte |
| in_ready | output | 1 | Decoder can take a byte |
| req_valid | output | 1 | Decoded request present |
| req_ready | input | 1 | Register bus accepts request |
| req_rd | output | 1 | 1 = read, 0 = write |
| req_block | output | 2 | Block index |
| req_offset | output | 5 | Register offset in block |
| req_sel | output | 4 | One-hot block select |
| req_seq | output | 8 | Sequence number |
| req_wdata | output | 32 | Signed argument |
| estop | output | 1 | Emergency-stop pulse |
| err_count | output | ERR_W | Dropped-frame counter |

## Verification
The bench sweeps all 256 opcode values. The sequence and argument bytes in the sweep are chosen so that 0xC0 and 0xDB show up in every frame position and must be escaped. A decoder that swapped the escape codes, took the argument most significant byte first, or read the read flag from the wrong bit would corrupt the fields on nearly every frame.

Single malformed frames are sent one at a time: bad sum, six bytes, eight bytes, a stray escape, and an empty END pair. A design that counted the empty pair, or did not count one of the others, would show a wrong error count. The error counter is then pushed past its limit; a design without saturation would wrap to a small value. Holding `req_ready` low shows whether request fields drift or input bytes slip in while a request waits.

// File: rtl/slip_cmd_pkg.sv
package slip_cmd_pkg;
  localparam logic [7:0] SLIP_END     = 8'hC0;
  localparam logic [7:0] SLIP_ESC     = 8'hDB;
  localparam logic [7:0] SLIP_ESC_END = 8'hDC;
  localparam logic [7:0] SLIP_ESC_ESC = 8'hDD;

  localparam int PAYLOAD_LEN = 7;
  localparam int BLK_W       = 2;
  localparam int OFF_W       = 5;
  localparam int NUM_BLK     = 1 << BLK_W;

  localparam logic [BLK_W-1:0] MISC_BLK  = '0;
  localparam logic [OFF_W-1:0] CTRL_OFF  = 5'd1;

  typedef struct packed {
    logic [7:0]       seq;
    logic             rd;
    logic [BLK_W-1:0] blk;
    logic [OFF_W-1:0] off;
    logic [31:0]      arg;
  } cmd_t;
endpackage

// File: rtl/slip_unescape.sv
module slip_unescape
  import slip_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic [7:0] byte_in,
  output logic       dec_valid,
  output logic [7:0] dec_byte,
  output logic       frame_end,
  output logic       esc_fault
);
  logic esc_pend;

  always_comb begin
    dec_valid = 1'b0;
    dec_byte  = byte_in;
    frame_end = 1'b0;
    esc_fault = 1'b0;
    if (take) begin
      if (byte_in == SLIP_END) begin
        frame_end = 1'b1;
        esc_fault = esc_pend;
      end else if (esc_pend) begin
        if (byte_in == SLIP_ESC_END) begin
          dec_valid = 1'b1;
          dec_byte  = SLIP_END;
        end else if (byte_in == SLIP_ESC_ESC) begin
          dec_valid = 1'b1;
          dec_byte  = SLIP_ESC;
        end else begin
          esc_fault = 1'b1;
        end
      end else if (byte_in != SLIP_ESC) begin
        dec_valid = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    esc_pend <= 1'b0;
    else if (take) esc_pend <= !esc_pend && (byte_in == SLIP_ESC);
  end

  // an escaped pair always yields one of the two reserved codes (R1)
  assert_escape_decode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && esc_pend && dec_valid) |-> (dec_byte == SLIP_END || dec_byte == SLIP_ESC));
endmodule

// File: rtl/slip_frame_assembler.sv
module slip_frame_assembler
  import slip_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dec_valid,
  input  logic [7:0] dec_byte,
  input  logic       frame_end,
  input  logic       esc_fault,
  output logic       frame_ok,
  output logic       frame_err,
  output cmd_t       cmd
);
  localparam int CNT_W = $clog2(PAYLOAD_LEN + 2);
  localparam int IDX_W = $clog2(PAYLOAD_LEN);
  localparam logic [CNT_W-1:0] LEN_C  = CNT_W'(PAYLOAD_LEN);
  localparam logic [CNT_W-1:0] OVER_C = CNT_W'(PAYLOAD_LEN + 1);

  logic [CNT_W-1:0] cnt;
  logic [7:0]       sum;
  logic             bad;
  logic [7:0]       pay [PAYLOAD_LEN];
  logic             empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      sum <= '0;
      bad <= 1'b0;
    end else if (frame_end) begin
      cnt <= '0;
      sum <= '0;
      bad <= 1'b0;
    end else begin
      if (dec_valid) begin
        if (cnt != OVER_C) cnt <= cnt + 1'b1;
        sum <= sum + dec_byte;
      end
      if (esc_fault) bad <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (dec_valid && cnt < LEN_C) pay[cnt[IDX_W-1:0]] <= dec_byte;
  end

  always_comb begin
    empty     = (cnt == '0) && !bad && !esc_fault;
    frame_ok  = frame_end && (cnt == LEN_C) && (sum == 8'h00) && !bad && !esc_fault;
    frame_err = frame_end && !frame_ok && !empty;
    cmd.seq   = pay[1];
    cmd.rd    = pay[2][7];
    cmd.blk   = pay[2][6:5];
    cmd.off   = pay[2][4:0];
    cmd.arg   = {pay[6], pay[5], pay[4], pay[3]};
  end

  // the byte counter stops one past a full payload (R5)
  assert_len_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= OVER_C);
endmodule

// File: rtl/slip_block_router.sv
module slip_block_router
  import slip_cmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_ready,
  input  cmd_t               cmd,
  output logic [NUM_BLK-1:0] sel,
  output logic               estop
);
  for (genvar b = 0; b < NUM_BLK; b++) begin : g_sel
    assign sel[b] = (cmd.blk == BLK_W'(b));
  end

  assign estop = req_valid && req_ready && !cmd.rd &&
                 (cmd.blk == MISC_BLK) && (cmd.off == CTRL_OFF) && cmd.arg[0];

  assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $onehot(sel));

  assert_estop_accepted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    estop |-> (req_valid && req_ready && sel[0]));
endmodule

// File: rtl/slip_cmd_decoder.sv
module slip_cmd_decoder
  import slip_cmd_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [7:0]         in_data,
  output logic               in_ready,
  output logic               req_valid,
  input  logic               req_ready,
  output logic               req_rd,
  output logic [BLK_W-1:0]   req_block,
  output logic [OFF_W-1:0]   req_offset,
  output logic [NUM_BLK-1:0] req_sel,
  output logic [7:0]         req_seq,
  output logic [31:0]        req_wdata,
  output logic               estop,
  output logic [ERR_W-1:0]   err_count
);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic       take;
  logic       dec_valid, frame_end, esc_fault;
  logic [7:0] dec_byte;
  logic       frame_ok, frame_err;
  cmd_t       cmd_new, cmd_q;

  assign in_ready = !req_valid;
  assign take     = in_valid && in_ready;

  slip_unescape u_unesc (
    .clk(clk), .rst_n(rst_n), .take(take), .byte_in(in_data),
    .dec_valid(dec_valid), .dec_byte(dec_byte),
    .frame_end(frame_end), .esc_fault(esc_fault)
  );

  slip_frame_assembler u_asm (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_byte(dec_byte),
    .frame_end(frame_end), .esc_fault(esc_fault),
    .frame_ok(frame_ok), .frame_err(frame_err), .cmd(cmd_new)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      cmd_q     <= '0;
      err_count <= '0;
    end else begin
      if (req_valid && req_ready) req_valid <= 1'b0;
      if (frame_ok) begin
        req_valid <= 1'b1;
        cmd_q     <= cmd_new;
      end
      if (frame_err && err_count != ERR_MAX) err_count <= err_count + 1'b1;
    end
  end

  slip_block_router u_route (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .cmd(cmd_q), .sel(req_sel), .estop(estop)
  );

  assign req_rd     = cmd_q.rd;
  assign req_block  = cmd_q.blk;
  assign req_offset = cmd_q.off;
  assign req_seq    = cmd_q.seq;
  assign req_wdata  = cmd_q.arg;

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_wdata) &&
      $stable(req_seq) && $stable(req_rd) && $stable(req_block) && $stable(req_offset)));

  assert_req_after_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(in_valid && in_ready && in_data == SLIP_END));

  assert_err_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (err_count == $past(err_count) || err_count == $past(err_count) + 1'b1));

  assert_good_no_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> (err_count == $past(err_count)));
endmodule

// File: tb/slip_cmd_decoder_test.sv
module slip_cmd_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int ERR_W = 8;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, req_ready = 1;
  logic [7:0] in_data = 0;
  logic in_ready, req_valid, req_rd, estop;
  logic [1:0] req_block;
  logic [4:0] req_offset;
  logic [3:0] req_sel;
  logic [7:0] req_seq;
  logic [31:0] req_wdata;
  logic [ERR_W-1:0] err_count;

  int errors = 0, checks = 0, got_n = 0, estop_n = 0;
  bit done = 0;
  logic g_rd; logic [1:0] g_blk; logic [4:0] g_off; logic [3:0] g_sel;
  logic [7:0] g_seq; logic [31:0] g_wd;

  always #(CLK_PERIOD/2) clk = ~clk;

  slip_cmd_decoder #(.ERR_W(ERR_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .req_valid(req_valid), .req_ready(req_ready),
    .req_rd(req_rd), .req_block(req_block), .req_offset(req_offset),
    .req_sel(req_sel), .req_seq(req_seq), .req_wdata(req_wdata),
    .estop(estop), .err_count(err_count)
  );

  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      got_n++;
      g_rd = req_rd; g_blk = req_block; g_off = req_offset;
      g_sel = req_sel; g_seq = req_seq; g_wd = req_wdata;
    end
    if (rst_n && estop) estop_n++;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put_raw(input logic [7:0] b);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_data = b;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic put_byte(input logic [7:0] b);
    if (b == 8'hC0) begin put_raw(8'hDB); put_raw(8'hDC); end
    else if (b == 8'hDB) begin put_raw(8'hDB); put_raw(8'hDD); end
    else put_raw(b);
  endtask

  task automatic send_cmd(input logic [7:0] seq, input logic [7:0] op,
                          input logic [31:0] arg, input logic [7:0] bump);
    logic [7:0] s;
    s = seq + op + arg[7:0] + arg[15:8] + arg[23:16] + arg[31:24];
    put_raw(8'hC0);
    put_byte((8'h00 - s) ^ bump);
    put_byte(seq); put_byte(op);
    put_byte(arg[7:0]); put_byte(arg[15:8]); put_byte(arg[23:16]); put_byte(arg[31:24]);
    put_raw(8'hC0);
  endtask

  function automatic logic [31:0] arg_of(input int i);
    if (i % 2 == 0) return {8'(i), 8'hC0, 8'(i * 7), 8'hDB};
    return {8'hDB, 8'(255 - i), 8'hC0, 8'(i)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n0, e0, est_exp, ec;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(req_valid == 0, "R11 req_valid", req_valid, 0);
    chk(in_ready == 1, "R11 in_ready", in_ready, 1);
    chk(err_count == 0, "R11 err_count", err_count, 0);

    // R1 R2 R3 sweep of every opcode, escape codes in every field
    est_exp = 0;
    for (int i = 0; i < 256; i++) begin
      logic [31:0] a;
      logic [7:0] sq;
      a = arg_of(i); sq = 8'(i) ^ 8'h5A;
      n0 = got_n;
      send_cmd(sq, 8'(i), a, 8'h00);
      repeat (2) @(negedge clk);
      if (i == 1 && a[0]) est_exp++;
      chk(got_n == n0 + 1 && g_rd == i[7] && g_blk == i[6:5] && g_off == i[4:0] &&
          g_sel == (4'b1 << i[6:5]) && g_seq == sq,
          "R2 fields", {g_rd, g_blk, g_off, g_seq}, {i[7], i[6:5], i[4:0], sq});
      chk(g_wd == a, "R3 R1 wdata", g_wd, a);
    end
    chk(err_count == 0, "R6 empty frames silent", err_count, 0);
    chk(estop_n == est_exp, "R9 sweep estop", estop_n, est_exp);

    // R1 explicit escape values
    send_cmd(8'hC0, 8'h45, 32'hDBC0_DBC0, 8'h00);
    repeat (2) @(negedge clk);
    chk(g_seq == 8'hC0 && g_wd == 32'hDBC0_DBC0, "R1 escapes", g_wd, 32'hDBC0_DBC0);

    // R9 estop cases
    e0 = estop_n;
    send_cmd(8'h01, 8'h81, 32'h1, 8'h00); repeat (2) @(negedge clk);
    send_cmd(8'h02, 8'h01, 32'h2, 8'h00); repeat (2) @(negedge clk);
    send_cmd(8'h03, 8'h21, 32'h1, 8'h00); repeat (2) @(negedge clk);
    chk(estop_n == e0, "R9 no estop", estop_n, e0);
    send_cmd(8'h04, 8'h01, 32'hFFFF_FFFF, 8'h00); repeat (2) @(negedge clk);
    chk(estop_n == e0 + 1, "R9 estop", estop_n, e0 + 1);

    // R8 back-pressure
    req_ready = 0;
    n0 = got_n;
    send_cmd(8'h77, 8'h62, 32'h8000_0001, 8'h00);
    repeat (5) @(negedge clk);
    chk(req_valid == 1 && in_ready == 0, "R8 held", {req_valid, in_ready}, 2'b10);
    chk(req_wdata == 32'h8000_0001 && req_seq == 8'h77 && req_block == 2'd3,
        "R8 stable", req_wdata, 32'h8000_0001);
    req_ready = 1;
    repeat (2) @(negedge clk);
    chk(got_n == n0 + 1 && req_valid == 0, "R8 released", got_n, n0 + 1);

    // R4 bad checksum
    n0 = got_n; ec = err_count;
    send_cmd(8'h10, 8'h02, 32'h1234_5678, 8'h01);
    repeat (2) @(negedge clk);
    chk(got_n == n0 && err_count == ec + 1, "R4 bad sum", err_count, ec + 1);

    // R5 short frame (six bytes summing to zero)
    ec = err_count;
    put_raw(8'hC0);
    put_raw(8'hFB); put_raw(8'h01); put_raw(8'h01); put_raw(8'h01); put_raw(8'h01); put_raw(8'h01);
    put_raw(8'hC0);
    repeat (2) @(negedge clk);
    chk(got_n == n0 && err_count == ec + 1, "R5 short", err_count, ec + 1);

    // R5 long frame (eight bytes summing to zero)
    ec = err_count;
    put_raw(8'hC0);
    for (int k = 0; k < 7; k++) put_raw(8'h01);
    put_raw(8'hF9);
    put_raw(8'hC0);
    repeat (2) @(negedge clk);
    chk(got_n == n0 && err_count == ec + 1, "R5 long", err_count, ec + 1);

    // R7 stray escape
    ec = err_count;
    put_raw(8'hC0);
    put_raw(8'h00); put_raw(8'hDB); put_raw(8'h41);
    for (int k = 0; k < 5; k++) put_raw(8'h00);
    put_raw(8'hC0);
    repeat (2) @(negedge clk);
    chk(got_n == n0 && err_count == ec + 1, "R7 bad escape", err_count, ec + 1);

    // R6 empty pair
    ec = err_count;
    put_raw(8'hC0); put_raw(8'hC0); put_raw(8'hC0);
    repeat (2) @(negedge clk);
    chk(got_n == n0 && err_count == ec, "R6 empty", err_count, ec);

    // R10 saturation
    for (int k = 0; k < 300; k++) begin put_raw(8'h01); put_raw(8'hC0); end
    repeat (2) @(negedge clk);
    chk(err_count == 8'hFF, "R10 saturate", err_count, 8'hFF);
    put_raw(8'h02); put_raw(8'hC0);
    send_cmd(8'h55, 8'h43, 32'hCAFE_0000, 8'h00);
    repeat (2) @(negedge clk);
    chk(err_count == 8'hFF && got_n == n0 + 1 && g_wd == 32'hCAFE_0000,
        "R10 held at max", err_count, 8'hFF);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule